// File: doc/BRIEF.md
# IDE Bus-Master I/O Window Decoder

This block holds the configuration registers of the disk-controller function of a PCI peripheral bridge and turns them into I/O chip selects. Three dwords are implemented: the command/status dword, a class-related dword and a base register that places a 16-byte bus-master register window anywhere in I/O space. The lower half of that window belongs to the primary channel and the upper half to the secondary channel.

The same I/O enable bit that opens the window also gates the fixed legacy command and control port ranges of both channels. While it is clear, a legacy access selects nothing, the write is dropped and the read data returned to the host is all-ones in every enabled byte lane. Decoding is combinational on the current register contents, so a register write is visible to the next I/O access.

Top module: `ide_bm_decoder`

## Requirements
- R1: After reset, configuration reads return 0x02800002 at offset 0x04, 0x00000000 at offset 0x0C and 0x00000001 at offset 0x20.
- R2: A write to offset 0x04 stores the merged value ANDed with 0x38000007 and then ORed with 0x02800002; bit 0 of that dword is the I/O enable.
- R3: Only byte lanes whose enable bit (bit n for byte n) is set take write data; the other lanes keep their old contents before the masking rules are applied.
- R4: A write to offset 0x0C keeps only bits 15:12 of the merged value.
- R5: A write to offset 0x20 keeps bits 15:4 of the merged value and forces bit 0 to 1; the base is bits 15:4.
- R6: Offsets other than 0x04, 0x0C and 0x20 read as zero and writes to them change no register.
- R7: With I/O enabled and a nonzero base, an access to base+0 through base+7 asserts the primary bus-master select.
- R8: With I/O enabled and a nonzero base, an access to base+8 through base+15 asserts the secondary bus-master select.
- R9: With a base of zero no bus-master select is asserted, whatever the enable bit.
- R10: With I/O disabled no bus-master or legacy select is asserted.
- R11: With I/O enabled, 0x1F0-0x1F7 and 0x3F4-0x3F7 assert the primary legacy select and 0x170-0x177 and 0x374-0x377 the secondary one; neighbouring addresses select nothing.
- R12: With I/O disabled, an access in a legacy range raises the float flag and the returned data is 0xFF in each enabled byte lane and 0 elsewhere; in all other cases the returned data is the controller data unchanged.
- R13: A new base takes effect on the first access after the configuration write that sets it.
- R14: Without an access request no select and no float flag are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (bits 7:2 select the dword) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| io_req | input | 1 | I/O access request |
| io_addr | input | 16 | I/O address |
| io_be | input | 4 | I/O byte lanes of the access |
| dev_rdata | input | 32 | Read data from the attached controllers |
| io_rdata | output | 32 | Read data returned to the host |
| bm_cs_pri | output | 1 | Primary bus-master window select |
| bm_cs_sec | output | 1 | Secondary bus-master window select |
| leg_cs_pri | output | 1 | Primary legacy port select |
| leg_cs_sec | output | 1 | Secondary legacy port select |
| leg_float | output | 1 | Legacy access while I/O disabled |

## Verification
The properties assume the configuration port stays quiet during reset and that a full-dword write to the base register carries meaningful data in its low half; they also take the legacy ranges and the bus-master window as possibly overlapping only where the base is placed over them. The stimulus holds cfg_wr low through reset, issues one configuration or I/O operation per cycle with every other input returned to idle, and never places the window on top of a legacy range, so each expected select vector has exactly one source.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    localparam logic [31:0] CMD_KEEP  = 32'h3800_0007;
    localparam logic [31:0] CMD_FORCE = 32'h0280_0002;
    localparam logic [31:0] CLS_KEEP  = 32'h0000_F000;
    localparam logic [31:0] BAR_FORCE = 32'h0000_0001;

    localparam logic [5:0] OFS_CMD = 6'h01;
    localparam logic [5:0] OFS_CLS = 6'h03;
    localparam logic [5:0] OFS_BAR = 6'h08;

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] cls;
        logic [31:0] bar;
    } cfg_state_t;

    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
    import ide_win_pkg::*;
#(
    parameter int IO_AW    = 16,
    parameter int WIN_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] cmd_q,
    output logic [31:0] bar_q
);
    localparam logic [31:0] BAR_KEEP =
        32'((64'(1) << IO_AW) - 64'(1)) & ~32'((64'(1) << WIN_LOG2) - 64'(1));

    cfg_state_t st_d, st_q;
    logic [5:0] dw;

    assign dw = cfg_addr[7:2];

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            unique case (dw)
                OFS_CMD: st_d.cmd = (be_merge(st_q.cmd, cfg_wdata, cfg_be) & CMD_KEEP) | CMD_FORCE;
                OFS_CLS: st_d.cls = be_merge(st_q.cls, cfg_wdata, cfg_be) & CLS_KEEP;
                OFS_BAR: st_d.bar = (be_merge(st_q.bar, cfg_wdata, cfg_be) & BAR_KEEP) | BAR_FORCE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmd <= CMD_FORCE;
            st_q.cls <= '0;
            st_q.bar <= BAR_FORCE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (dw)
            OFS_CMD: cfg_rdata = st_q.cmd;
            OFS_CLS: cfg_rdata = st_q.cls;
            OFS_BAR: cfg_rdata = st_q.bar;
            default: cfg_rdata = '0;
        endcase
    end

    assign cmd_q = st_q.cmd;
    assign bar_q = st_q.bar;

endmodule

// File: rtl/ide_bm_window.sv
module ide_bm_window #(
    parameter int IO_AW    = 16,
    parameter int WIN_LOG2 = 4
) (
    input  logic             io_en,
    input  logic             io_req,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [31:0]      bar_q,
    output logic             cs_pri,
    output logic             cs_sec
);
    localparam int BW = IO_AW - WIN_LOG2;

    logic [BW-1:0] base;
    logic          in_win;

    assign base   = bar_q[IO_AW-1:WIN_LOG2];
    assign in_win = io_req && io_en && (base != '0) && (io_addr[IO_AW-1:WIN_LOG2] == base);
    assign cs_pri = in_win && !io_addr[WIN_LOG2-1];
    assign cs_sec = in_win &&  io_addr[WIN_LOG2-1];

endmodule

// File: rtl/ide_legacy_gate.sv
module ide_legacy_gate #(
    parameter int              IO_AW   = 16,
    parameter logic [15:0]     CMD_PRI = 16'h01F0,
    parameter logic [15:0]     CTL_PRI = 16'h03F4,
    parameter logic [15:0]     CMD_SEC = 16'h0170,
    parameter logic [15:0]     CTL_SEC = 16'h0374
) (
    input  logic             io_en,
    input  logic             io_req,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [3:0]       io_be,
    input  logic [31:0]      dev_rdata,
    output logic [31:0]      io_rdata,
    output logic             cs_pri,
    output logic             cs_sec,
    output logic             float_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] hit;
    logic [31:0]    ones;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [15:0] CMDB = (ch == 0) ? CMD_PRI : CMD_SEC;
        localparam logic [15:0] CTLB = (ch == 0) ? CTL_PRI : CTL_SEC;
        assign hit[ch] = io_req &&
            ((io_addr[IO_AW-1:3] == CMDB[IO_AW-1:3]) ||
             (io_addr[IO_AW-1:2] == CTLB[IO_AW-1:2]));
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign ones[b*8 +: 8] = {8{io_be[b]}};
    end

    assign cs_pri   = io_en && hit[0];
    assign cs_sec   = io_en && hit[1];
    assign float_o  = !io_en && (hit != '0);
    assign io_rdata = float_o ? ones : dev_rdata;

endmodule

// File: rtl/ide_bm_decoder.sv
module ide_bm_decoder #(
    parameter int IO_AW    = 16,
    parameter int WIN_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             io_req,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [3:0]       io_be,
    input  logic [31:0]      dev_rdata,
    output logic [31:0]      io_rdata,
    output logic             bm_cs_pri,
    output logic             bm_cs_sec,
    output logic             leg_cs_pri,
    output logic             leg_cs_sec,
    output logic             leg_float
);
    logic [31:0] cmd_q;
    logic [31:0] bar_q;

    ide_cfg_regs #(.IO_AW(IO_AW), .WIN_LOG2(WIN_LOG2)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cmd_q     (cmd_q),
        .bar_q     (bar_q)
    );

    ide_bm_window #(.IO_AW(IO_AW), .WIN_LOG2(WIN_LOG2)) u_win (
        .io_en   (cmd_q[0]),
        .io_req  (io_req),
        .io_addr (io_addr),
        .bar_q   (bar_q),
        .cs_pri  (bm_cs_pri),
        .cs_sec  (bm_cs_sec)
    );

    ide_legacy_gate #(.IO_AW(IO_AW)) u_leg (
        .io_en     (cmd_q[0]),
        .io_req    (io_req),
        .io_addr   (io_addr),
        .io_be     (io_be),
        .dev_rdata (dev_rdata),
        .io_rdata  (io_rdata),
        .cs_pri    (leg_cs_pri),
        .cs_sec    (leg_cs_sec),
        .float_o   (leg_float)
    );

endmodule

// File: rtl/ide_bm_decoder_chk.sv
module ide_bm_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [7:0]  cfg_addr,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cmd_q,
    input logic [31:0] bar_q,
    input logic        io_req,
    input logic        bm_cs_pri,
    input logic        bm_cs_sec,
    input logic        leg_cs_pri,
    input logic        leg_cs_sec,
    input logic        leg_float
);
    logic any_cs;
    assign any_cs = bm_cs_pri || bm_cs_sec || leg_cs_pri || leg_cs_sec;

    a_r2_cmd_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q & ~32'h3A80_0007) == 32'h0) && ((cmd_q & 32'h0280_0002) == 32'h0280_0002));

    a_r5_bar_shape: assert property (@(posedge clk) disable iff (!rst_n)
        bar_q[0] && (bar_q[3:1] == 3'b000) && (bar_q[31:16] == 16'h0));

    a_r5_bar_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr[7:2] == 6'h08 && cfg_be == 4'hF)
        |=> (bar_q[15:4] == $past(cfg_wdata[15:4])));

    a_r9_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_cs_pri || bm_cs_sec) |-> (bar_q[15:4] != 12'h0));

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q[0] |-> !any_cs);

    a_r12_float_excl: assert property (@(posedge clk) disable iff (!rst_n)
        leg_float |-> (!leg_cs_pri && !leg_cs_sec && !cmd_q[0]));

    a_r14_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req |-> (!any_cs && !leg_float));

    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bm_cs_pri, bm_cs_sec}) && $onehot0({leg_cs_pri, leg_cs_sec}));

endmodule

bind ide_bm_decoder ide_bm_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cmd_q      (cmd_q),
    .bar_q      (bar_q),
    .io_req     (io_req),
    .bm_cs_pri  (bm_cs_pri),
    .bm_cs_sec  (bm_cs_sec),
    .leg_cs_pri (leg_cs_pri),
    .leg_cs_sec (leg_cs_sec),
    .leg_float  (leg_float)
);

// File: tb/sim_ide_bm_decoder.sv
`timescale 1ns/1ps
module sim_ide_bm_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_req = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] dev_rdata = '0;
    logic [31:0] io_rdata;
    logic        bm_cs_pri, bm_cs_sec, leg_cs_pri, leg_cs_sec, leg_float;

    always #10 clk = ~clk;

    ide_bm_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_req(io_req), .io_addr(io_addr), .io_be(io_be), .dev_rdata(dev_rdata),
        .io_rdata(io_rdata), .bm_cs_pri(bm_cs_pri), .bm_cs_sec(bm_cs_sec),
        .leg_cs_pri(leg_cs_pri), .leg_cs_sec(leg_cs_sec), .leg_float(leg_float)
    );

    typedef struct {
        bit          is_io;
        logic [4:0]  sel;
        logic [31:0] data;
        string       tag;
    } item_t;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        io_req = 0; cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        io_req = 0; cfg_wr = 0; cfg_addr = a;
        it.is_io = 0; it.sel = '0; it.data = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // sel = {bm_cs_pri, bm_cs_sec, leg_cs_pri, leg_cs_sec, leg_float}
    task automatic io_check(input logic req, input logic [15:0] a, input logic [3:0] be,
                            input logic [4:0] sel, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        cfg_wr = 0; io_req = req; io_addr = a; io_be = be; dev_rdata = 32'h1234_5678;
        it.is_io = 1; it.sel = sel; it.data = exp; it.tag = tag;
        q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_run++;
                if (it.is_io) begin
                    if ({bm_cs_pri, bm_cs_sec, leg_cs_pri, leg_cs_sec, leg_float} !== it.sel ||
                        io_rdata !== it.data) begin
                        n_fail++;
                        $display("FAIL %s: sel=%b data=%h expected sel=%b data=%h", it.tag,
                                 {bm_cs_pri, bm_cs_sec, leg_cs_pri, leg_cs_sec, leg_float},
                                 io_rdata, it.sel, it.data);
                    end
                end else if (cfg_rdata !== it.data) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected %h", it.tag, cfg_rdata, it.data);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 5000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] PASS = 32'h1234_5678;

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        cfg_check(8'h04, 32'h0280_0002, "R1 cmd reset");
        cfg_check(8'h0C, 32'h0000_0000, "R1 class reset");
        cfg_check(8'h20, 32'h0000_0001, "R1 base reset");

        // R12 / R10 disabled legacy access floats
        io_check(1, 16'h01F0, 4'b0011, 5'b00001, 32'h0000_FFFF, "R12 float two lanes");

        // R2 command masking
        cfg_write(8'h04, 4'hF, 32'hFFFF_FFFF);
        cfg_check(8'h04, 32'h3A80_0007, "R2 cmd all ones");
        // R3 partial byte write: only byte 0 cleared
        cfg_write(8'h04, 4'b0001, 32'h0000_0000);
        cfg_check(8'h04, 32'h3A80_0002, "R3 cmd byte0 only");
        cfg_write(8'h04, 4'hF, 32'h0000_0001);
        cfg_check(8'h04, 32'h0280_0003, "R2 cmd enable");

        // R9 base zero never decodes
        io_check(1, 16'h0005, 4'hF, 5'b00000, PASS, "R9 base zero low");
        io_check(1, 16'h000C, 4'hF, 5'b00000, PASS, "R9 base zero high");

        // R5 base write
        cfg_write(8'h20, 4'hF, 32'hABCD_C0F6);
        cfg_check(8'h20, 32'h0000_C0F1, "R5 base write");

        // R7 / R8 window
        io_check(1, 16'hC0F0, 4'hF, 5'b10000, PASS, "R7 primary first");
        io_check(1, 16'hC0F7, 4'hF, 5'b10000, PASS, "R7 primary last");
        io_check(1, 16'hC0F8, 4'hF, 5'b01000, PASS, "R8 secondary first");
        io_check(1, 16'hC0FF, 4'hF, 5'b01000, PASS, "R8 secondary last");
        io_check(1, 16'hC100, 4'hF, 5'b00000, PASS, "R8 above window");
        io_check(1, 16'hC0EF, 4'hF, 5'b00000, PASS, "R7 below window");

        // R11 legacy enabled
        io_check(1, 16'h01F7, 4'hF, 5'b00100, PASS, "R11 pri cmd");
        io_check(1, 16'h03F6, 4'hF, 5'b00100, PASS, "R11 pri ctl");
        io_check(1, 16'h0177, 4'hF, 5'b00010, PASS, "R11 sec cmd");
        io_check(1, 16'h0374, 4'hF, 5'b00010, PASS, "R11 sec ctl");
        io_check(1, 16'h01F8, 4'hF, 5'b00000, PASS, "R11 past pri cmd");
        io_check(1, 16'h03F3, 4'hF, 5'b00000, PASS, "R11 below pri ctl");
        io_check(1, 16'h0378, 4'hF, 5'b00000, PASS, "R11 past sec ctl");

        // R14 no request
        io_check(0, 16'hC0F0, 4'hF, 5'b00000, PASS, "R14 idle window");
        io_check(0, 16'h01F0, 4'hF, 5'b00000, PASS, "R14 idle legacy");

        // R13 relocation visible on next access
        cfg_write(8'h20, 4'hF, 32'h0000_1000);
        io_check(1, 16'h1008, 4'hF, 5'b01000, PASS, "R13 new base");
        io_check(1, 16'hC0F0, 4'hF, 5'b00000, PASS, "R13 old base gone");

        // R4 class dword
        cfg_write(8'h0C, 4'hF, 32'hFFFF_FFFF);
        cfg_check(8'h0C, 32'h0000_F000, "R4 class keep");
        cfg_write(8'h0C, 4'b0010, 32'h0000_0000);
        cfg_check(8'h0C, 32'h0000_0000, "R4 class byte1 clear");

        // R6 unimplemented offset
        cfg_write(8'h10, 4'hF, 32'hFFFF_FFFF);
        cfg_check(8'h10, 32'h0000_0000, "R6 unimplemented read");
        cfg_check(8'h04, 32'h0280_0003, "R6 cmd untouched");
        cfg_check(8'h20, 32'h0000_1001, "R6 base untouched");

        // R10 disable
        cfg_write(8'h04, 4'hF, 32'h0000_0000);
        cfg_check(8'h04, 32'h0280_0002, "R10 cmd disabled");
        io_check(1, 16'h1008, 4'hF, 5'b00000, PASS, "R10 window off");
        io_check(1, 16'h0374, 4'hF, 5'b00001, 32'hFFFF_FFFF, "R12 float full");
        io_check(1, 16'h0172, 4'b0100, 5'b00001, 32'h00FF_0000, "R12 float lane2");
        io_check(1, 16'h0200, 4'hF, 5'b00000, PASS, "R12 non-legacy pass");

        // R3 base partial write
        cfg_write(8'h20, 4'b0010, 32'h0000_FF00);
        cfg_check(8'h20, 32'h0000_FF01, "R3 base byte1");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule